// File: doc/BRIEF.md
# Modem Escape Sequence Detector

This block sits beside a UART receiver and watches the stream of received bytes for the modem escape pattern. The pattern is a run of one programmable command byte, repeated at least a programmed number of times. The line must be quiet before the run starts and after it ends, and the bytes inside the run must follow each other closely. When all of these conditions hold, the block produces a single-cycle pulse. That pulse feeds bit 18 of the interrupt bank.

All timing is counted in bit-time ticks supplied by the baud generator. An idle counter restarts at every received byte and counts ticks from there. Three limits are compared against that counter:
- the quiet time required before the first command byte;
- the largest spacing allowed between command bytes;
- the quiet time required after the last command byte.

A run tracker counts qualifying command bytes. A fire stage raises the pulse once the trailing quiet time has passed.

Top module: `escseq_detector`

## Requirements
- R1: After reset the detect output is low and the line counts as having been idle for the saturated maximum, so a command byte received before any tick may start a run.
- R2: A qualifying run of at least `cfg_count` command bytes raises `detect_pulse` for exactly one cycle. The pulse appears in the cycle after the clock edge that counts the `cfg_post`-th tick after the last byte, and is followed by no second pulse.
- R3: The command byte is the value on `cfg_char`; the same bytes are not matched once `cfg_char` holds a different value.
- R4: A run shorter than `cfg_count` bytes produces no pulse, however long the line then stays idle.
- R5: A command byte whose tick count since the previous byte is at most `cfg_gap` extends the run. A larger count breaks the run; that byte then starts a new run of one only if the count is at least `cfg_pre`.
- R6: A command byte that would start a run does so only if at least `cfg_pre` ticks have passed since the previous received byte.
- R7: Any byte other than the command byte clears the run, and the next command byte must again satisfy the pre-idle limit of R6.
- R8: A non-command byte that arrives before the post-idle limit is reached cancels the pending detection. A command byte arriving within `cfg_gap` during that window extends the run and restarts the post-idle count.
- R9: Time advances only on cycles where `bit_tick` is high. Every received byte restarts the idle count at zero, and the count saturates at its maximum.
- R10: A detection clears the run, so later command bytes must build a complete new run before another pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | CHAR_W | Received byte |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cfg_char | input | CHAR_W | Command byte value |
| cfg_count | input | CW | Minimum run length |
| cfg_gap | input | TW | Largest tick spacing inside a run |
| cfg_pre | input | TW | Ticks of quiet required before a run |
| cfg_post | input | TW | Ticks of quiet required after a run |
| detect_pulse | output | 1 | One-cycle escape detect pulse |

## Verification
- A byte strobe sampled on one edge clears the idle count at that edge.
- The run count reflects the byte on the same edge.
- `detect_pulse` is registered, so it rises one edge after the edge that brings the idle count up to `cfg_post`.

The bench drives inputs on falling edges and samples there as well. After the final tick of the post-idle window, it checks three points in order: the output is still low at that falling edge, high at the next, and low again at the one after. A running count of pulses also catches any early or extra pulse in the negative scenarios.

// File: rtl/escseq_pkg.sv
package escseq_pkg;

   // Classification of one received byte by the run tracker
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_EXTEND = 2'd1,
      EV_START  = 2'd2,
      EV_DROP   = 2'd3
   } run_event_e;

endpackage

// File: rtl/escseq_idle_timer.sv
module escseq_idle_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic          bit_tick,
   output logic [TW-1:0] idle_cnt
);
   localparam logic [TW-1:0] IDLE_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idle_cnt <= IDLE_MAX;
      else if (rx_valid)
         idle_cnt <= '0;
      else if (bit_tick && (idle_cnt != IDLE_MAX))
         idle_cnt <= idle_cnt + 1'b1;
   end

   // R9: a byte restarts the quiet time
   assert_clear_on_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (idle_cnt == '0));

   // R9: without a tick, time does not advance
   assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !bit_tick) |=> $stable(idle_cnt));

endmodule

// File: rtl/escseq_run_tracker.sv
module escseq_run_tracker
   import escseq_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int CW     = 4,
   parameter int TW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic [CHAR_W-1:0] cfg_char,
   input  logic [CW-1:0]     cfg_count,
   input  logic [TW-1:0]     cfg_gap,
   input  logic [TW-1:0]     cfg_pre,
   input  logic [TW-1:0]     idle_cnt,
   input  logic              fire,
   output logic              armed
);
   localparam logic [CW-1:0] RUN_MAX = '1;

   logic [CW-1:0] run_cnt;
   run_event_e    ev;

   always_comb begin
      if (!rx_valid)
         ev = EV_NONE;
      else if (rx_data != cfg_char)
         ev = EV_DROP;
      else if ((run_cnt != '0) && (idle_cnt <= cfg_gap))
         ev = EV_EXTEND;
      else if (idle_cnt >= cfg_pre)
         ev = EV_START;
      else
         ev = EV_DROP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (fire)
         run_cnt <= '0;
      else begin
         case (ev)
            EV_EXTEND: run_cnt <= (run_cnt == RUN_MAX) ? run_cnt : run_cnt + 1'b1;
            EV_START:  run_cnt <= {{(CW-1){1'b0}}, 1'b1};
            EV_DROP:   run_cnt <= '0;
            default:   run_cnt <= run_cnt;
         endcase
      end
   end

   assign armed = (run_cnt != '0) && (run_cnt >= cfg_count);

   // R7: a foreign byte clears the run
   assert_foreign_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (rx_data != cfg_char)) |=> (run_cnt == '0));

   // R6: no run starts without the pre-idle quiet time
   assert_pre_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (run_cnt == '0) && (idle_cnt < cfg_pre)) |=> (run_cnt == '0));

   // R10: a detection empties the run
   assert_fire_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (run_cnt == '0));

   // R9: the run only changes on a byte or a detection
   assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !fire) |=> $stable(run_cnt));

endmodule

// File: rtl/escseq_fire.sv
module escseq_fire #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          armed,
   input  logic          rx_valid,
   input  logic [TW-1:0] idle_cnt,
   input  logic [TW-1:0] cfg_post,
   output logic          fire,
   output logic          detect_q
);
   assign fire = armed && !rx_valid && (idle_cnt >= cfg_post);

   always_ff @(posedge clk) begin
      if (!rst_n)
         detect_q <= 1'b0;
      else
         detect_q <= fire;
   end

   // R2: the pulse lasts a single cycle
   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      detect_q |=> !detect_q);

endmodule

// File: rtl/escseq_detector.sv
module escseq_detector #(
   parameter int CHAR_W = 8,
   parameter int CW     = 4,
   parameter int TW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              bit_tick,
   input  logic [CHAR_W-1:0] cfg_char,
   input  logic [CW-1:0]     cfg_count,
   input  logic [TW-1:0]     cfg_gap,
   input  logic [TW-1:0]     cfg_pre,
   input  logic [TW-1:0]     cfg_post,
   output logic              detect_pulse
);
   generate
      if (TW < 2) begin : g_bad_tw
         $error("escseq_detector: TW must be at least 2");
      end
      if (CW < 2) begin : g_bad_cw
         $error("escseq_detector: CW must be at least 2");
      end
      if (CHAR_W < 1) begin : g_bad_char
         $error("escseq_detector: CHAR_W must be at least 1");
      end
   endgenerate

   logic [TW-1:0] idle_cnt;
   logic          armed;
   logic          fire;

   escseq_idle_timer #(.TW(TW)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .bit_tick (bit_tick),
      .idle_cnt (idle_cnt)
   );

   escseq_run_tracker #(.CHAR_W(CHAR_W), .CW(CW), .TW(TW)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .cfg_char  (cfg_char),
      .cfg_count (cfg_count),
      .cfg_gap   (cfg_gap),
      .cfg_pre   (cfg_pre),
      .idle_cnt  (idle_cnt),
      .fire      (fire),
      .armed     (armed)
   );

   escseq_fire #(.TW(TW)) u_fire (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .rx_valid (rx_valid),
      .idle_cnt (idle_cnt),
      .cfg_post (cfg_post),
      .fire     (fire),
      .detect_q (detect_pulse)
   );

   // R2: a pulse follows a full post-idle window on an armed run
   assert_post_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      detect_pulse |-> $past(armed && (idle_cnt >= cfg_post)));

   // R8: a byte in the same cycle blocks the pulse
   assert_byte_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !detect_pulse);

endmodule

// File: tb/escseq_detector_tb.sv
module escseq_detector_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CHAR_W = 8;
   localparam int CW     = 4;
   localparam int TW     = 8;
   localparam int GAP    = 4;
   localparam int PRE    = 6;
   localparam int POST   = 6;
   localparam logic [7:0] CMD   = 8'h2B;
   localparam logic [7:0] OTHER = 8'h58;
   localparam logic [7:0] ALT   = 8'h41;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_valid = 1'b0;
   logic [CHAR_W-1:0] rx_data = '0;
   logic              bit_tick = 1'b0;
   logic [CHAR_W-1:0] cfg_char = CMD;
   logic [CW-1:0]     cfg_count = CW'(3);
   logic [TW-1:0]     cfg_gap = TW'(GAP);
   logic [TW-1:0]     cfg_pre = TW'(PRE);
   logic [TW-1:0]     cfg_post = TW'(POST);
   logic              detect_pulse;

   int n_checks = 0;
   int n_bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   escseq_detector #(.CHAR_W(CHAR_W), .CW(CW), .TW(TW)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .bit_tick     (bit_tick),
      .cfg_char     (cfg_char),
      .cfg_count    (cfg_count),
      .cfg_gap      (cfg_gap),
      .cfg_pre      (cfg_pre),
      .cfg_post     (cfg_post),
      .detect_pulse (detect_pulse)
   );

   always @(negedge clk) if (rst_n && detect_pulse) pulses++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         @(negedge clk);
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
      end
   endtask

   // three command bytes, each spaced by sp ticks
   task automatic run3(input logic [7:0] b, input int sp);
      send(b); ticks(sp); send(b); ticks(sp); send(b);
   endtask

   // walk the post-idle window and check the exact pulse cycle
   task automatic finish_post(input bit hit, input string req);
      int p0 = pulses;
      ticks(POST - 1);
      ticks(1);
      chk(detect_pulse == 1'b0, req, detect_pulse, 0);
      @(negedge clk);
      chk(detect_pulse == hit, req, detect_pulse, hit);
      @(negedge clk);
      chk(detect_pulse == 1'b0, req, detect_pulse, 0);
      ticks(20);
      chk((pulses - p0) == int'(hit), req, pulses - p0, int'(hit));
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(detect_pulse == 1'b0, "R1 reset low", detect_pulse, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(detect_pulse == 1'b0, "R1 after release", detect_pulse, 0);
   endtask

   task automatic t_basic();
      // first byte right after reset, no ticks yet: saturated idle qualifies
      run3(CMD, 2);
      finish_post(1'b1, "R1 R2 basic run");
   endtask

   task automatic t_char();
      @(negedge clk); cfg_char = ALT;
      run3(ALT, 1);
      finish_post(1'b1, "R3 new char detected");
      run3(CMD, 1);
      finish_post(1'b0, "R3 old char ignored");
      @(negedge clk); cfg_char = CMD;
      ticks(PRE);
   endtask

   task automatic t_short();
      send(CMD); ticks(1); send(CMD);
      finish_post(1'b0, "R4 short run");
   endtask

   task automatic t_gap();
      send(CMD); ticks(GAP + 1); send(CMD); ticks(2); send(CMD);
      finish_post(1'b0, "R5 gap too long");
      ticks(PRE);
      run3(CMD, GAP);
      finish_post(1'b1, "R5 gap at limit");
      send(CMD); ticks(PRE + 1); send(CMD); ticks(1); send(CMD); ticks(1); send(CMD);
      finish_post(1'b1, "R5 restart after long gap");
   endtask

   task automatic t_pre();
      send(OTHER); ticks(PRE - 1);
      run3(CMD, 1);
      finish_post(1'b0, "R6 pre-idle short");
      send(OTHER); ticks(PRE);
      run3(CMD, 1);
      finish_post(1'b1, "R6 pre-idle at limit");
   endtask

   task automatic t_foreign();
      send(CMD); ticks(1); send(CMD); ticks(1); send(OTHER); ticks(1);
      run3(CMD, 1);
      finish_post(1'b0, "R7 foreign byte mid run");
   endtask

   task automatic t_trailing();
      int p0;
      run3(CMD, 1); ticks(POST - 3);
      p0 = pulses;
      send(OTHER); ticks(POST + 10);
      chk(pulses == p0, "R8 trailing byte cancels", pulses - p0, 0);
      ticks(PRE);
      run3(CMD, 1); ticks(GAP - 1); send(CMD);
      finish_post(1'b1, "R8 extra command byte extends");
   endtask

   task automatic t_noticks();
      int p0;
      run3(CMD, 1);
      p0 = pulses;
      repeat (40) @(negedge clk);
      chk(pulses == p0, "R9 no ticks no time", pulses - p0, 0);
      finish_post(1'b1, "R9 ticks complete window");
   endtask

   task automatic t_after();
      run3(CMD, 1);
      finish_post(1'b1, "R10 first detection");
      send(CMD); ticks(1); send(CMD);
      finish_post(1'b0, "R10 run emptied");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_char();
      t_short();
      ticks(PRE);
      t_gap();
      t_pre();
      ticks(PRE);
      t_foreign();
      ticks(PRE);
      t_trailing();
      ticks(PRE);
      t_noticks();
      ticks(PRE);
      t_after();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

endmodule